// File: doc/BRIEF.md
# Polyphase FIR Sub-Filter Bank

This block is the filter front end of a polyphase channelizer. A stream of complex fixed-point samples for one sub-band is dealt out over `NCH` branches: sample n of a frame goes to branch n mod `NCH`. Each branch is a short FIR with `NTAPS` real weights. One weight exists for every branch and tap pair, and the same weight set serves every data stream that passes through. Each branch result is a real-by-complex product summed over the taps. It is rounded and saturated to a narrower width. The results are ready for a later `NCH`-point complex FFT.

Samples are collected in blocks of `KBLK` frames. Once a block has arrived, the input stops accepting samples and the sub-filters run one at a time, in branch-major order: branch 0 for every frame of the block, then branch 1, and so on. One tap is evaluated per cycle. Each result carries its branch index, and the first valid result of each block also carries a start marker. Weights are written through a simple write port while the block is collecting. A write made while it is computing is dropped and raises a sticky error flag.

Top module: `pfb_bank`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `cfg_err` is 0.
- R2: A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. Sample n of a block (n counting from 0) belongs to branch n mod NCH and to frame n / NCH of the block. Once NCH*KBLK samples have been taken, `in_ready` stays low for exactly NCH*KBLK*NTAPS cycles and then returns high.
- R3: The result for branch b and absolute frame g is y = sum over t = 0..NTAPS-1 of w[b][t] * x_b(g-t). Here x_b(g-t) is the sample of branch b from t frames earlier, so tap 0 weights the newest sample. The real and imaginary parts use the same real weight, and the history runs on across blocks.
- R4: Each component of the sum s is output as (s + 2^(RSHIFT-1)) >>> RSHIFT, an arithmetic shift. It is then saturated to the signed range [-2^(OW-1), 2^(OW-1)-1].
- R5: Within a block, results appear in branch-major order: index i = b*KBLK + f for branch b and block frame f. `out_branch` carries b.
- R6: Result i of a block is presented on `out_valid` for exactly one cycle. It appears (i+1)*NTAPS cycles after the edge that took the block's last sample.
- R7: No result is produced for absolute frames 0..NTAPS-2, counted from reset; `out_valid` stays low in their slots. Every later frame produces one result per branch.
- R8: `out_first` is high together with the first valid result of each block and is low otherwise.
- R9: A weight write (`cw_en` high while `in_ready` is high) stores `cw_data` as w[b][t], with `cw_addr` = b*NTAPS + t. Every block whose last sample arrives after the write uses the new weight.
- R10: A weight write while `in_ready` is low changes no weight. It sets `cfg_err` on the next edge, and `cfg_err` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block is collecting and takes a sample this cycle |
| in_re | input | 16 | Sample real part, signed |
| in_im | input | 16 | Sample imaginary part, signed |
| cw_en | input | 1 | Weight write strobe |
| cw_addr | input | 5 | Weight address, branch*NTAPS + tap |
| cw_data | input | 16 | Weight value, signed |
| cfg_err | output | 1 | Sticky flag: weight write attempted while computing |
| out_valid | output | 1 | Result present |
| out_first | output | 1 | First valid result of a block |
| out_branch | output | 3 | Branch index of the result |
| out_re | output | 18 | Result real part, signed |
| out_im | output | 18 | Result imaginary part, signed |

## Verification
The edge that takes a block's last sample starts the timing. Result i of that block is due (i+1)*NTAPS cycles later, and `in_ready` comes back NCH*KBLK*NTAPS cycles later. A rejected weight write shows on `cfg_err` one edge after the write. The reference model tracks these due cycles from its own record of accepted samples and weight writes. It compares `in_ready`, `cfg_err` and `out_valid` away from the clock edge in every cycle. The result fields are compared only in the cycle where a result is due, so a result that comes early, late or in the wrong order is reported.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

   typedef enum logic {
      ST_FILL = 1'b0,
      ST_RUN  = 1'b1
   } pfb_state_e;

   function automatic int pow2_ceil(input int v);
      return 1 << $clog2(v);
   endfunction

endpackage

// File: rtl/pfb_store.sv
module pfb_store #(
   parameter int DW = 16,
   parameter int NCH = 8,
   parameter int SLOTS = 8,
   parameter int BW = $clog2(NCH),
   parameter int SW = $clog2(SLOTS)
) (
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [SW-1:0]        wr_slot,
   input  logic [BW-1:0]        wr_br,
   input  logic signed [DW-1:0] wr_re,
   input  logic signed [DW-1:0] wr_im,
   input  logic [SW-1:0]        rd_slot,
   input  logic [BW-1:0]        rd_br,
   output logic signed [DW-1:0] rd_re,
   output logic signed [DW-1:0] rd_im
);
   localparam int DEPTH = SLOTS * NCH;

   logic signed [DW-1:0] mem_re [DEPTH];
   logic signed [DW-1:0] mem_im [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_re[{wr_slot, wr_br}] <= wr_re;
         mem_im[{wr_slot, wr_br}] <= wr_im;
      end
   end

   assign rd_re = mem_re[{rd_slot, rd_br}];
   assign rd_im = mem_im[{rd_slot, rd_br}];

endmodule

// File: rtl/pfb_coef.sv
module pfb_coef #(
   parameter int WW = 16,
   parameter int NCH = 8,
   parameter int NTAPS = 4,
   parameter int AW = $clog2(NCH) + $clog2(NTAPS)
) (
   input  logic                 clk,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic signed [WW-1:0] wr_data,
   input  logic [AW-1:0]        rd_addr,
   output logic signed [WW-1:0] rd_w
);
   logic signed [WW-1:0] mem [NCH*NTAPS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_w = mem[rd_addr];

endmodule

// File: rtl/pfb_seq.sv
module pfb_seq
   import pfb_pkg::*;
#(
   parameter int NCH = 8,
   parameter int NTAPS = 4,
   parameter int KBLK = 2,
   parameter int SLOTS = 8,
   parameter int BW = $clog2(NCH),
   parameter int TW = $clog2(NTAPS),
   parameter int SW = $clog2(SLOTS),
   parameter int KW = (KBLK > 1) ? $clog2(KBLK) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   output logic          wr_en,
   output logic [SW-1:0] wr_slot,
   output logic [BW-1:0] wr_br,
   output logic [SW-1:0] rd_slot,
   output logic [BW-1:0] rd_br,
   output logic [TW-1:0] rd_tap,
   output logic          step_en,
   output logic          first_tap,
   output logic          last_tap,
   output logic          emit,
   output logic          tag_first
);
   localparam int PCW = $clog2(NTAPS + KBLK + 1);

   pfb_state_e     state;
   logic [BW-1:0]  wbr, rb;
   logic [KW-1:0]  wfr, rf;
   logic [TW-1:0]  rt;
   logic [SW-1:0]  base;
   logic [PCW-1:0] prior, prior_nxt;
   logic           first_pend;
   logic           wb_last, wf_last, rb_last, rf_last;

   assign wb_last   = (wbr == BW'(NCH - 1));
   assign wf_last   = (wfr == KW'(KBLK - 1));
   assign rb_last   = (rb == BW'(NCH - 1));
   assign rf_last   = (rf == KW'(KBLK - 1));

   assign in_ready  = (state == ST_FILL);
   assign wr_en     = in_ready && in_valid;
   assign wr_slot   = base + SW'(wfr);
   assign wr_br     = wbr;

   assign step_en   = (state == ST_RUN);
   assign rd_slot   = base + SW'(rf) - SW'(rt);
   assign rd_br     = rb;
   assign rd_tap    = rt;
   assign first_tap = (rt == '0);
   assign last_tap  = (rt == TW'(NTAPS - 1));
   assign emit      = (int'(prior) + int'(rf) + 1) >= NTAPS;
   assign tag_first = first_pend;

   always_comb begin
      if (int'(prior) + KBLK >= NTAPS) prior_nxt = PCW'(NTAPS);
      else prior_nxt = prior + PCW'(KBLK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_FILL;
         wbr        <= '0;
         wfr        <= '0;
         rb         <= '0;
         rf         <= '0;
         rt         <= '0;
         base       <= '0;
         prior      <= '0;
         first_pend <= 1'b0;
      end else begin
         case (state)
            ST_FILL: begin
               if (in_valid) begin
                  if (wb_last) begin
                     wbr <= '0;
                     if (wf_last) begin
                        wfr        <= '0;
                        rb         <= '0;
                        rf         <= '0;
                        rt         <= '0;
                        first_pend <= 1'b1;
                        state      <= ST_RUN;
                     end else begin
                        wfr <= wfr + 1'b1;
                     end
                  end else begin
                     wbr <= wbr + 1'b1;
                  end
               end
            end
            ST_RUN: begin
               if (last_tap) begin
                  rt <= '0;
                  if (emit) first_pend <= 1'b0;
                  if (rf_last) begin
                     rf <= '0;
                     if (rb_last) begin
                        rb    <= '0;
                        base  <= base + SW'(KBLK);
                        prior <= prior_nxt;
                        state <= ST_FILL;
                     end else begin
                        rb <= rb + 1'b1;
                     end
                  end else begin
                     rf <= rf + 1'b1;
                  end
               end else begin
                  rt <= rt + 1'b1;
               end
            end
            default: state <= ST_FILL;
         endcase
      end
   end

endmodule

// File: rtl/pfb_mac.sv
module pfb_mac #(
   parameter int DW = 16,
   parameter int WW = 16,
   parameter int OW = 18,
   parameter int NTAPS = 4,
   parameter int RSHIFT = 14,
   parameter int BW = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_en,
   input  logic                 first_tap,
   input  logic                 last_tap,
   input  logic                 emit,
   input  logic                 tag_first,
   input  logic [BW-1:0]        tag_br,
   input  logic signed [DW-1:0] x_re,
   input  logic signed [DW-1:0] x_im,
   input  logic signed [WW-1:0] w,
   output logic                 y_valid,
   output logic                 y_first,
   output logic [BW-1:0]        y_br,
   output logic signed [OW-1:0] y_re,
   output logic signed [OW-1:0] y_im
);
   localparam int PW = DW + WW;
   localparam int AW = PW + $clog2(NTAPS) + 1;
   localparam logic signed [AW-1:0] RC   = AW'(1) <<< (RSHIFT - 1);
   localparam logic signed [AW-1:0] OMAX = (AW'(1) <<< (OW - 1)) - AW'(1);
   localparam logic signed [AW-1:0] OMIN = -(AW'(1) <<< (OW - 1));

   logic signed [DW-1:0] xs [2];
   logic signed [OW-1:0] ys [2];

   assign xs[0] = x_re;
   assign xs[1] = x_im;

   for (genvar c = 0; c < 2; c++) begin : g_lane
      logic signed [PW-1:0] prod;
      logic signed [AW-1:0] acc_q, psum, rnd, shf;
      logic signed [OW-1:0] sat, y_q;

      always_comb begin
         prod = xs[c] * w;
         psum = (first_tap ? '0 : acc_q) + AW'(prod);
         rnd  = psum + RC;
         shf  = rnd >>> RSHIFT;
         if (shf > OMAX)      sat = OMAX[OW-1:0];
         else if (shf < OMIN) sat = OMIN[OW-1:0];
         else                 sat = shf[OW-1:0];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc_q <= '0;
            y_q   <= '0;
         end else if (step_en) begin
            acc_q <= psum;
            if (last_tap) y_q <= sat;
         end
      end

      assign ys[c] = y_q;
   end

   assign y_re = ys[0];
   assign y_im = ys[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_valid <= 1'b0;
         y_first <= 1'b0;
         y_br    <= '0;
      end else begin
         y_valid <= step_en && last_tap && emit;
         y_first <= step_en && last_tap && emit && tag_first;
         if (step_en && last_tap) y_br <= tag_br;
      end
   end

   // R6: results are at least NTAPS cycles apart, never back to back
   p_out_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid |=> !y_valid);

endmodule

// File: rtl/pfb_bank.sv
module pfb_bank
   import pfb_pkg::*;
#(
   parameter int NCH = 8,
   parameter int NTAPS = 4,
   parameter int KBLK = 2,
   parameter int DW = 16,
   parameter int WW = 16,
   parameter int OW = 18,
   parameter int RSHIFT = 14
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   in_valid,
   output logic                                   in_ready,
   input  logic signed [DW-1:0]                   in_re,
   input  logic signed [DW-1:0]                   in_im,
   input  logic                                   cw_en,
   input  logic [$clog2(NCH)+$clog2(NTAPS)-1:0]   cw_addr,
   input  logic signed [WW-1:0]                   cw_data,
   output logic                                   cfg_err,
   output logic                                   out_valid,
   output logic                                   out_first,
   output logic [$clog2(NCH)-1:0]                 out_branch,
   output logic signed [OW-1:0]                   out_re,
   output logic signed [OW-1:0]                   out_im
);
   localparam int BW    = $clog2(NCH);
   localparam int TW    = $clog2(NTAPS);
   localparam int CAW   = BW + TW;
   localparam int SLOTS = pow2_ceil(NTAPS + KBLK - 1);
   localparam int SW    = $clog2(SLOTS);

   initial begin
      assert (NCH >= 2 && (1 << BW) == NCH)
         else $error("NCH must be a power of two, at least 2");
      assert (NTAPS >= 2 && (1 << TW) == NTAPS)
         else $error("NTAPS must be a power of two, at least 2");
      assert (KBLK >= 1) else $error("KBLK must be at least 1");
      assert (RSHIFT >= 1 && OW <= DW + WW) else $error("bad output scaling");
   end

   logic          wr_en, step_en, first_tap, last_tap, emit, tag_first;
   logic [SW-1:0] wr_slot, rd_slot;
   logic [BW-1:0] wr_br, rd_br;
   logic [TW-1:0] rd_tap;
   logic signed [DW-1:0] x_re, x_im;
   logic signed [WW-1:0] w_cur;

   pfb_seq #(
      .NCH(NCH), .NTAPS(NTAPS), .KBLK(KBLK), .SLOTS(SLOTS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_br(wr_br),
      .rd_slot(rd_slot), .rd_br(rd_br), .rd_tap(rd_tap),
      .step_en(step_en), .first_tap(first_tap), .last_tap(last_tap),
      .emit(emit), .tag_first(tag_first)
   );

   pfb_store #(
      .DW(DW), .NCH(NCH), .SLOTS(SLOTS)
   ) u_store (
      .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_br(wr_br),
      .wr_re(in_re), .wr_im(in_im),
      .rd_slot(rd_slot), .rd_br(rd_br), .rd_re(x_re), .rd_im(x_im)
   );

   pfb_coef #(
      .WW(WW), .NCH(NCH), .NTAPS(NTAPS), .AW(CAW)
   ) u_coef (
      .clk(clk), .wr_en(cw_en && in_ready), .wr_addr(cw_addr),
      .wr_data(cw_data), .rd_addr({rd_br, rd_tap}), .rd_w(w_cur)
   );

   pfb_mac #(
      .DW(DW), .WW(WW), .OW(OW), .NTAPS(NTAPS), .RSHIFT(RSHIFT), .BW(BW)
   ) u_mac (
      .clk(clk), .rst_n(rst_n), .step_en(step_en),
      .first_tap(first_tap), .last_tap(last_tap), .emit(emit),
      .tag_first(tag_first), .tag_br(rd_br),
      .x_re(x_re), .x_im(x_im), .w(w_cur),
      .y_valid(out_valid), .y_first(out_first), .y_br(out_branch),
      .y_re(out_re), .y_im(out_im)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_err <= 1'b0;
      else if (cw_en && !in_ready) cfg_err <= 1'b1;
   end

   // R10: a write while computing raises the flag on the next edge
   p_busy_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_en && !in_ready) |=> cfg_err);

   // R10: the flag never clears outside reset
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

   // R8: the start marker only travels with a valid result
   p_first_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_first |-> out_valid);

   // R2: when collection stops no result is in flight
   p_ready_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> !out_valid);

endmodule

// File: tb/sim_pfb_bank.sv
module sim_pfb_bank;
   localparam int NCH = 8;
   localparam int NTAPS = 4;
   localparam int KBLK = 2;
   localparam int RSHIFT = 14;
   localparam int OW = 18;
   localparam int BW = $clog2(NCH);
   localparam int TW = $clog2(NTAPS);
   localparam int CAW = BW + TW;
   localparam int NFR = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid, in_ready, cw_en, cfg_err;
   logic out_valid, out_first;
   logic signed [15:0] in_re, in_im, cw_data;
   logic [CAW-1:0] cw_addr;
   logic [BW-1:0] out_branch;
   logic signed [OW-1:0] out_re, out_im;

   always #5 clk = ~clk;

   pfb_bank #(.NCH(NCH), .NTAPS(NTAPS), .KBLK(KBLK), .RSHIFT(RSHIFT), .OW(OW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_re(in_re), .in_im(in_im), .cw_en(cw_en), .cw_addr(cw_addr),
      .cw_data(cw_data), .cfg_err(cfg_err), .out_valid(out_valid),
      .out_first(out_first), .out_branch(out_branch),
      .out_re(out_re), .out_im(out_im)
   );

   typedef struct {
      longint due;
      int     re;
      int     im;
      int     br;
      bit     first;
      string  tag;
   } item_t;

   item_t  q[$];
   int     hre[NCH][NFR];
   int     him[NCH][NFR];
   int     wt[NCH][NTAPS];
   longint cyc = 0;
   longint run_end = 0;
   bit     exp_ready = 1'b1;
   bit     exp_err = 1'b0;
   bit     phase2 = 1'b0;
   int     cnt = 0;
   int     gnext = 0;
   int     sfr = 0;
   int     n_out = 0;
   int     checks = 0;
   int     errors = 0;
   bit     done = 1'b0;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic int round_sat(input longint s, inout bit sat);
      longint r;
      r = (s + (64'sd1 <<< (RSHIFT - 1))) >>> RSHIFT;
      if (r > (64'sd1 <<< (OW - 1)) - 1) begin
         sat = 1'b1;
         return (1 << (OW - 1)) - 1;
      end
      if (r < -(64'sd1 <<< (OW - 1))) begin
         sat = 1'b1;
         return -(1 << (OW - 1));
      end
      return int'(r);
   endfunction

   task automatic compute_block();
      bit any;
      any = 1'b0;
      for (int b = 0; b < NCH; b++) begin
         for (int f = 0; f < KBLK; f++) begin
            int g;
            int i;
            g = gnext + f;
            i = b * KBLK + f;
            if (g >= NTAPS - 1) begin
               longint sr;
               longint si;
               bit sat;
               item_t it;
               sr = 0;
               si = 0;
               sat = 1'b0;
               for (int t = 0; t < NTAPS; t++) begin
                  sr += longint'(wt[b][t]) * longint'(hre[b][g-t]);
                  si += longint'(wt[b][t]) * longint'(him[b][g-t]);
               end
               it.re = round_sat(sr, sat);
               it.im = round_sat(si, sat);
               it.due = cyc + longint'((i + 1) * NTAPS);
               it.br = b;
               it.first = !any;
               it.tag = sat ? "R4" : (phase2 ? "R9" : "R3");
               any = 1'b1;
               q.push_back(it);
            end
         end
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   always @(posedge clk) begin
      if (rst_n) begin
         cyc++;
         if (cw_en) begin
            if (exp_ready) wt[int'(cw_addr) / NTAPS][int'(cw_addr) % NTAPS] = int'(cw_data);
            else exp_err = 1'b1;
         end
         if (!exp_ready) begin
            if (cyc == run_end) exp_ready = 1'b1;
         end else if (in_valid) begin
            hre[cnt % NCH][gnext + cnt / NCH] = int'(in_re);
            him[cnt % NCH][gnext + cnt / NCH] = int'(in_im);
            cnt++;
            if (cnt == NCH * KBLK) begin
               compute_block();
               cnt = 0;
               gnext += KBLK;
               exp_ready = 1'b0;
               run_end = cyc + longint'(NCH * KBLK * NTAPS);
            end
         end
      end
   end

   // comparison away from the active edge, every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit expv;
         item_t it;
         chk(in_ready === exp_ready, "R2 in_ready", longint'(in_ready), longint'(exp_ready));
         chk(cfg_err === exp_err, "R10 cfg_err", longint'(cfg_err), longint'(exp_err));
         expv = (q.size() > 0) && (q[0].due == cyc);
         chk(out_valid === expv, "R6 out_valid timing", longint'(out_valid), longint'(expv));
         if (!expv) chk(out_first === 1'b0, "R8 out_first idle", longint'(out_first), 0);
         if (out_valid) n_out++;
         if (expv) begin
            it = q.pop_front();
            if (out_valid) begin
               chk(int'(out_re) == it.re, {it.tag, " out_re"}, longint'(out_re), longint'(it.re));
               chk(int'(out_im) == it.im, {it.tag, " out_im"}, longint'(out_im), longint'(it.im));
               chk(int'(out_branch) == it.br, "R5 out_branch", longint'(out_branch), longint'(it.br));
               chk(out_first == it.first, "R8 out_first", longint'(out_first), longint'(it.first));
            end
         end
      end
   end

   function automatic logic signed [15:0] pat_val(input int kind, input int b, input int g, input bit im);
      int v;
      case (kind)
         1: v = im ? 32767 : -32768;
         2: v = im ? ((b * 911 + g * 3001) % 20001) - 10000 : ((g * 577 - b * 4099) % 30001);
         default: v = im ? ((g * 7 + b * 13) * 419 % 25001) - 12500 : ((g * NCH + b) * 1237 % 30001) - 15000;
      endcase
      return 16'(v);
   endfunction

   task automatic send(input logic signed [15:0] r, input logic signed [15:0] i);
      in_re = r;
      in_im = i;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_block(input int kind, input bit gaps);
      for (int n = 0; n < NCH * KBLK; n++) begin
         send(pat_val(kind, n % NCH, sfr + n / NCH, 1'b0), pat_val(kind, n % NCH, sfr + n / NCH, 1'b1));
         if (gaps && (n % 3 == 1)) repeat (2) @(negedge clk);
      end
      sfr += KBLK;
   endtask

   task automatic wcoef(input int b, input int t, input int v);
      cw_addr = CAW'(b * NTAPS + t);
      cw_data = 16'(v);
      cw_en = 1'b1;
      @(negedge clk);
      cw_en = 1'b0;
   endtask

   task automatic wait_idle();
      while (!in_ready) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      in_valid = 1'b0;
      in_re = '0;
      in_im = '0;
      cw_en = 1'b0;
      cw_addr = '0;
      cw_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready === 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
      chk(out_valid === 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
      chk(cfg_err === 1'b0, "R1 cfg_err after reset", longint'(cfg_err), 0);

      for (int b = 0; b < NCH; b++)
         for (int t = 0; t < NTAPS; t++)
            wcoef(b, t, ((b * NTAPS + t) * 2741) % 4001 - 2000);

      send_block(0, 1'b0);
      wait_idle();
      chk(n_out == 0, "R7 results while filling", longint'(n_out), 0);

      send_block(0, 1'b1);
      wait_idle();
      chk(n_out == NCH, "R7 results of first full frame", longint'(n_out), longint'(NCH));

      send_block(2, 1'b0);
      wcoef(3, 1, 12345);
      wait_idle();
      chk(cfg_err === 1'b1, "R10 sticky flag after busy write", longint'(cfg_err), 1);

      phase2 = 1'b1;
      for (int b = 0; b < NCH; b++)
         for (int t = 0; t < NTAPS; t++)
            wcoef(b, t, (b == 0) ? -32768 : (b == 1) ? 32767 : ((b * 53 + t * 9001) % 6001) - 3000);

      send_block(1, 1'b0);
      wait_idle();
      send_block(1, 1'b1);
      wait_idle();
      send_block(0, 1'b0);
      wait_idle();
      repeat (NTAPS + 3) @(negedge clk);
      chk(q.size() == 0, "R6 every due result delivered", longint'(q.size()), 0);
      chk(n_out == NCH * (1 + 4 * KBLK), "R7 total result count", longint'(n_out),
          longint'(NCH * (1 + 4 * KBLK)));
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule